// File: doc/BRIEF.md
# Banked Request Router

The router sits between a multi-issue core and a group of independent single-port storage banks. Each cycle every request port may present one read or write. The router takes a bank number from the address bits just above the line offset, so neighbouring lines land in neighbouring banks. Every request whose bank is wanted by no other port goes through in the same cycle. When several ports want the same bank, exactly one of them is granted. The others see `req_ready` low and must hold their request unchanged until they are granted.

Each bank has its own arbiter. A bank that had no conflict in the previous cycle favours the lowest-numbered requesting port. After a conflict, the next cycle's search for that bank starts at the port just after the winner and wraps around. A port that keeps its request up is therefore served within a bounded number of cycles.

Read data comes back one cycle after the grant, on the response lane of the port that issued the read. A combinational count reports how many valid requests were stalled in the current cycle. The default build has four ports and four banks. Each bank holds a quarter of the 256-word space.

Top module: `bank_req_router`

## Requirements
- R1: For a word address `a`, the bank number is `a[OFFSET_W+BANK_W-1:OFFSET_W]` (bits 3:2 by default). The bank row is the remaining bits, upper bits first and offset bits last. Every one of the NBANKS×2^(ADDR_W−BANK_W) addresses has its own storage word, so a read returns the value last written to that same address.
- R2: Each bank is granted to at most one port per cycle. `req_ready[p]` is never high while `req_valid[p]` is low.
- R3: A valid request whose bank is targeted by no other valid port in the same cycle is granted in that cycle. This holds however many other ports are active.
- R4: If a bank had at most one requester in the previous cycle (or the previous cycle was reset), the lowest-numbered port requesting it now is granted.
- R5: If a bank had two or more requesters in a cycle where port w won, then in the next cycle the first requesting port found in the order w+1, w+2, … (wrapping past NPORTS−1 to 0) is granted for that bank.
- R6: A port that holds a stalled request is granted after at most NPORTS−1 stalled cycles.
- R7: A read granted in cycle t raises `rsp_valid` of the same port for exactly cycle t+1, with the data on that port's `rsp_rdata` lane. A granted write produces no response.
- R8: `conflict_count` equals the number of valid requests not granted in the current cycle, in the same cycle.
- R9: While reset is asserted and in the first cycle after it, `rsp_valid` is all zero. With no valid request, `req_ready` is zero and `conflict_count` is zero.
- R10: A write granted in cycle t is seen by a read of the same address granted in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_we | input | NPORTS | 1 = write, 0 = read, per port |
| req_addr | input | NPORTS*ADDR_W | Word address per port; port p at bits p*ADDR_W upward |
| req_wdata | input | NPORTS*DATA_W | Write data per port |
| req_ready | output | NPORTS | Request granted this cycle |
| rsp_valid | output | NPORTS | Read data valid, one cycle after grant |
| rsp_rdata | output | NPORTS*DATA_W | Read data per port lane |
| conflict_count | output | $clog2(NPORTS+1) | Number of stalled valid requests this cycle |

## Verification
The bench aims at all four ports hitting one bank at once. A fixed-priority design would pass the first grant and then fail the rotation check when a freshly re-issued low-numbered port tries to jump ahead of a held one. A distinct-bank burst catches a router that serialises requests that do not conflict, and it also catches a count that misses or double-counts stalls. A write followed on the next cycle by a read of the same address, along with a full write-and-readback sweep of every address, exposes wrong bank or row bit slicing and read data returned on the wrong port's lane or on the wrong cycle. Long random runs with held requests check the stall bound.

// File: rtl/brr_pkg.sv
`timescale 1ns/1ps
package brr_pkg;

   typedef enum logic [0:0] {
      ARB_FIXED  = 1'b0,
      ARB_ROTATE = 1'b1
   } arb_mode_e;

   function automatic int wrap_next(input int cur, input int n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/brr_port_decode.sv
`timescale 1ns/1ps
module brr_port_decode #(
   parameter int ADDR_W   = 8,
   parameter int OFFSET_W = 2,
   parameter int BANK_W   = 2,
   localparam int LOC_W   = ADDR_W - BANK_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [LOC_W-1:0]  row
);

   assign bank = addr[OFFSET_W +: BANK_W];

   generate
      if (OFFSET_W == 0) begin : g_no_offset
         assign row = addr[ADDR_W-1:BANK_W];
      end else begin : g_with_offset
         assign row = {addr[ADDR_W-1:OFFSET_W+BANK_W], addr[OFFSET_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/brr_bank_arbiter.sv
`timescale 1ns/1ps
module brr_bank_arbiter #(
   parameter int NPORTS = 4,
   parameter brr_pkg::arb_mode_e ARB_MODE = brr_pkg::ARB_ROTATE,
   localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   localparam int CNT_W = $clog2(NPORTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] req,
   output logic              gnt_vld,
   output logic [IDX_W-1:0]  gnt_idx,
   output logic [CNT_W-1:0]  extra_cnt
);

   logic [IDX_W-1:0] ptr_q;
   logic             found;
   int               n_req;

   if (NPORTS < 2) begin : g_bad_ports
      $error("brr_bank_arbiter needs at least two ports");
   end

   always_comb begin
      found   = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < NPORTS; k++) begin
         int idx;
         idx = int'(ptr_q) + k;
         if (idx >= NPORTS) idx = idx - NPORTS;
         if (!found && req[idx]) begin
            found   = 1'b1;
            gnt_idx = IDX_W'(idx);
         end
      end
   end

   assign gnt_vld   = found;
   assign n_req     = $countones(req);
   assign extra_cnt = (n_req > 1) ? CNT_W'(n_req - 1) : '0;

   generate
      if (ARB_MODE == brr_pkg::ARB_ROTATE) begin : g_rotate
         logic [IDX_W-1:0] ptr_d;
         always_comb begin
            if (n_req > 1)
               ptr_d = IDX_W'(brr_pkg::wrap_next(int'(gnt_idx), NPORTS));
            else
               ptr_d = '0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ptr_q <= '0;
            else        ptr_q <= ptr_d;
         end
      end else begin : g_fixed
         assign ptr_q = '0;
      end
   endgenerate

endmodule

// File: rtl/brr_bank_ram.sv
`timescale 1ns/1ps
module brr_bank_ram #(
   parameter int DATA_W = 32,
   parameter int ROW_W  = 6,
   localparam int DEPTH = 1 << ROW_W
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we)  mem[row] <= wdata;
      if (en && !we) rdata    <= mem[row];
   end

endmodule

// File: rtl/bank_req_router.sv
`timescale 1ns/1ps
module bank_req_router #(
   parameter int NPORTS   = 4,
   parameter int NBANKS   = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int OFFSET_W = 2,
   parameter brr_pkg::arb_mode_e ARB_MODE = brr_pkg::ARB_ROTATE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORTS-1:0]          req_valid,
   input  logic [NPORTS-1:0]          req_we,
   input  logic [NPORTS*ADDR_W-1:0]   req_addr,
   input  logic [NPORTS*DATA_W-1:0]   req_wdata,
   output logic [NPORTS-1:0]          req_ready,
   output logic [NPORTS-1:0]          rsp_valid,
   output logic [NPORTS*DATA_W-1:0]   rsp_rdata,
   output logic [$clog2(NPORTS+1)-1:0] conflict_count
);

   localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
   localparam int ROW_W  = ADDR_W - BANK_W;
   localparam int IDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1;
   localparam int CNT_W  = $clog2(NPORTS + 1);

   if (NBANKS < 2 || (NBANKS & (NBANKS - 1)) != 0) begin : g_bad_banks
      $error("NBANKS must be a power of two of at least 2");
   end
   if (NPORTS < 2) begin : g_bad_ports
      $error("NPORTS must be at least 2");
   end
   if (OFFSET_W < 0 || OFFSET_W + BANK_W >= ADDR_W) begin : g_bad_addr
      $error("address too narrow for offset and bank fields");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [BANK_W-1:0] p_bank  [NPORTS];
   logic [ROW_W-1:0]  p_row   [NPORTS];
   logic [DATA_W-1:0] p_wdata [NPORTS];

   logic [NPORTS-1:0] bank_req  [NBANKS];
   logic              gnt_vld   [NBANKS];
   logic [IDX_W-1:0]  gnt_idx   [NBANKS];
   logic [CNT_W-1:0]  extra_cnt [NBANKS];
   logic [DATA_W-1:0] b_rdata   [NBANKS];

   logic [NPORTS-1:0] granted;
   logic [NPORTS-1:0] rsp_valid_q;
   logic [BANK_W-1:0] rsp_bank_q [NPORTS];

   genvar gp, gb;

   generate
      for (gp = 0; gp < NPORTS; gp++) begin : g_port
         brr_port_decode #(
            .ADDR_W   (ADDR_W),
            .OFFSET_W (OFFSET_W),
            .BANK_W   (BANK_W)
         ) u_dec (
            .addr (req_addr[gp*ADDR_W +: ADDR_W]),
            .bank (p_bank[gp]),
            .row  (p_row[gp])
         );
         assign p_wdata[gp] = req_wdata[gp*DATA_W +: DATA_W];
         assign rsp_rdata[gp*DATA_W +: DATA_W] = b_rdata[rsp_bank_q[gp]];
      end
   endgenerate

   always_comb begin
      for (int b = 0; b < NBANKS; b++) begin
         for (int p = 0; p < NPORTS; p++) begin
            bank_req[b][p] = req_valid[p] && (p_bank[p] == BANK_W'(b));
         end
      end
   end

   generate
      for (gb = 0; gb < NBANKS; gb++) begin : g_bank
         logic              b_en;
         logic              b_we;
         logic [ROW_W-1:0]  b_row;
         logic [DATA_W-1:0] b_wdata;

         brr_bank_arbiter #(
            .NPORTS   (NPORTS),
            .ARB_MODE (ARB_MODE)
         ) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (bank_req[gb]),
            .gnt_vld   (gnt_vld[gb]),
            .gnt_idx   (gnt_idx[gb]),
            .extra_cnt (extra_cnt[gb])
         );

         assign b_en    = gnt_vld[gb];
         assign b_we    = req_we[gnt_idx[gb]];
         assign b_row   = p_row[gnt_idx[gb]];
         assign b_wdata = p_wdata[gnt_idx[gb]];

         brr_bank_ram #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W)
         ) u_ram (
            .clk   (clk),
            .en    (b_en),
            .we    (b_we),
            .row   (b_row),
            .wdata (b_wdata),
            .rdata (b_rdata[gb])
         );
      end
   endgenerate

   always_comb begin
      granted = '0;
      for (int p = 0; p < NPORTS; p++) begin
         for (int b = 0; b < NBANKS; b++) begin
            if (gnt_vld[b] && gnt_idx[b] == IDX_W'(p)) granted[p] = 1'b1;
         end
      end
   end

   assign req_ready = granted & req_valid;

   always_comb begin
      conflict_count = '0;
      for (int b = 0; b < NBANKS; b++) begin
         conflict_count = conflict_count + extra_cnt[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= '0;
         for (int p = 0; p < NPORTS; p++) rsp_bank_q[p] <= '0;
      end else begin
         for (int p = 0; p < NPORTS; p++) begin
            rsp_valid_q[p] <= req_ready[p] && !req_we[p];
            if (req_ready[p]) rsp_bank_q[p] <= p_bank[p];
         end
      end
   end

   assign rsp_valid = rsp_valid_q;

endmodule

// File: rtl/bank_req_router_chk.sv
`timescale 1ns/1ps
module bank_req_router_chk #(
   parameter int NPORTS   = 4,
   parameter int NBANKS   = 4,
   parameter int ADDR_W   = 8,
   parameter int OFFSET_W = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NPORTS-1:0]           req_valid,
   input logic [NPORTS-1:0]           req_we,
   input logic [NPORTS*ADDR_W-1:0]    req_addr,
   input logic [NPORTS-1:0]           req_ready,
   input logic [NPORTS-1:0]           rsp_valid,
   input logic [$clog2(NPORTS+1)-1:0] conflict_count
);

   localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
   localparam int SC_W   = $clog2(NPORTS + 1) + 1;

   logic [BANK_W-1:0] pbank   [NPORTS];
   logic [NPORTS-1:0] on_bank [NBANKS];
   logic [NPORTS-1:0] lowest  [NBANKS];
   logic [NBANKS-1:0] busy_q;
   logic [SC_W-1:0]   stall_cnt [NPORTS];

   always_comb begin
      for (int p = 0; p < NPORTS; p++) pbank[p] = req_addr[p*ADDR_W+OFFSET_W +: BANK_W];
      for (int b = 0; b < NBANKS; b++) begin
         for (int p = 0; p < NPORTS; p++) on_bank[b][p] = req_valid[p] && pbank[p] == BANK_W'(b);
         lowest[b] = on_bank[b] & (~on_bank[b] + 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         for (int p = 0; p < NPORTS; p++) stall_cnt[p] <= '0;
      end else begin
         for (int b = 0; b < NBANKS; b++) busy_q[b] <= $countones(on_bank[b]) > 1;
         for (int p = 0; p < NPORTS; p++) begin
            if (req_valid[p] && !req_ready[p]) stall_cnt[p] <= stall_cnt[p] + 1'b1;
            else                               stall_cnt[p] <= '0;
         end
      end
   end

   AST_STALLED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      int'(conflict_count) == $countones(req_valid) - $countones(req_ready)); // R8

   genvar gp, gb;
   generate
      for (gp = 0; gp < NPORTS; gp++) begin : g_p
         AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[gp] |-> req_valid[gp]); // R2
         AST_LONE_REQ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[gp] && $countones(on_bank[pbank[gp]]) == 1) |-> req_ready[gp]); // R3
         AST_READ_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[gp] && req_ready[gp] && !req_we[gp]) |=> rsp_valid[gp]); // R7
         AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[gp] && req_ready[gp] && !req_we[gp]) |=> !rsp_valid[gp]); // R7
         AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            int'(stall_cnt[gp]) <= NPORTS - 1); // R6
      end
      for (gb = 0; gb < NBANKS; gb++) begin : g_b
         AST_ONE_GRANT_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(req_ready & on_bank[gb]) <= 1); // R2
         AST_LOWEST_WINS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy_q[gb] && on_bank[gb] != '0) |-> ((req_ready & lowest[gb]) != '0)); // R4
      end
   endgenerate

endmodule

bind bank_req_router bank_req_router_chk #(
   .NPORTS   (NPORTS),
   .NBANKS   (NBANKS),
   .ADDR_W   (ADDR_W),
   .OFFSET_W (OFFSET_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_we         (req_we),
   .req_addr       (req_addr),
   .req_ready      (req_ready),
   .rsp_valid      (rsp_valid),
   .conflict_count (conflict_count)
);

// File: tb/bank_req_router_tb.sv
`timescale 1ns/1ps
module bank_req_router_tb;

   localparam int NP  = 4;
   localparam int NB  = 4;
   localparam int AW  = 8;
   localparam int DW  = 32;
   localparam int OFF = 2;
   localparam int BW  = 2;
   localparam int CW  = $clog2(NP + 1);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NP-1:0]      req_valid = '0;
   logic [NP-1:0]      req_we = '0;
   logic [NP*AW-1:0]   req_addr = '0;
   logic [NP*DW-1:0]   req_wdata = '0;
   logic [NP-1:0]      req_ready;
   logic [NP-1:0]      rsp_valid;
   logic [NP*DW-1:0]   rsp_rdata;
   logic [CW-1:0]      conflict_count;

   bank_req_router #(
      .NPORTS(NP), .NBANKS(NB), .ADDR_W(AW), .DATA_W(DW), .OFFSET_W(OFF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .conflict_count(conflict_count)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit          pend_v  [NP];
   bit          pend_we [NP];
   logic [AW-1:0] pend_a [NP];
   logic [DW-1:0] pend_d [NP];
   int          wait_c  [NP];
   bit          exp_rv  [NP];
   logic [DW-1:0] exp_rd [NP];
   int          mptr    [NB];
   logic [DW-1:0] mmem  [1 << AW];

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int bank_of(input logic [AW-1:0] a);
      return int'(a[OFF +: BW]);
   endfunction

   task automatic post(input int p, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      pend_v[p] = 1'b1; pend_we[p] = we; pend_a[p] = a; pend_d[p] = d; wait_c[p] = 0;
   endtask

   task automatic cycle();
      bit gnt [NP];
      int exp_cnt;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         check(rsp_valid[p] == exp_rv[p], $sformatf("R7 rsp_valid port %0d", p), rsp_valid[p], exp_rv[p]);
         if (exp_rv[p])
            check(rsp_rdata[p*DW +: DW] === exp_rd[p], $sformatf("R1 R10 read data port %0d", p),
                  rsp_rdata[p*DW +: DW], exp_rd[p]);
      end
      for (int p = 0; p < NP; p++) begin
         req_valid[p] = pend_v[p];
         req_we[p]    = pend_v[p] & pend_we[p];
         req_addr[p*AW +: AW]  = pend_a[p];
         req_wdata[p*DW +: DW] = pend_d[p];
      end
      #1;
      exp_cnt = 0;
      for (int p = 0; p < NP; p++) gnt[p] = 1'b0;
      for (int b = 0; b < NB; b++) begin
         int cnt, win;
         cnt = 0; win = -1;
         for (int p = 0; p < NP; p++) if (pend_v[p] && bank_of(pend_a[p]) == b) cnt++;
         for (int k = 0; k < NP; k++) begin
            int idx;
            idx = (mptr[b] + k) % NP;
            if (win < 0 && pend_v[idx] && bank_of(pend_a[idx]) == b) win = idx;
         end
         if (win >= 0) gnt[win] = 1'b1;
         if (cnt > 1) exp_cnt += cnt - 1;
         mptr[b] = (cnt > 1) ? (win + 1) % NP : 0;
      end
      for (int p = 0; p < NP; p++)
         check(req_ready[p] == gnt[p], $sformatf("R2 R3 R4 R5 ready port %0d", p), req_ready[p], gnt[p]);
      check(int'(conflict_count) == exp_cnt, "R8 conflict_count", conflict_count, exp_cnt);
      for (int p = 0; p < NP; p++) begin
         exp_rv[p] = gnt[p] && !pend_we[p];
         if (exp_rv[p]) exp_rd[p] = mmem[pend_a[p]];
      end
      for (int p = 0; p < NP; p++) begin
         if (gnt[p]) begin
            if (pend_we[p]) mmem[pend_a[p]] = pend_d[p];
            pend_v[p] = 1'b0;
            wait_c[p] = 0;
         end else if (pend_v[p]) begin
            wait_c[p]++;
            if (wait_c[p] > NP - 1)
               check(1'b0, $sformatf("R6 stall length port %0d", p), wait_c[p], NP - 1);
         end
      end
   endtask

   task automatic drain();
      for (int n = 0; n < 3 * NP; n++) cycle();
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5eed_1234);
      for (int p = 0; p < NP; p++) begin
         pend_v[p] = 0; pend_we[p] = 0; pend_a[p] = '0; pend_d[p] = '0;
         wait_c[p] = 0; exp_rv[p] = 0; exp_rd[p] = '0;
      end
      for (int b = 0; b < NB; b++) mptr[b] = 0;

      // R9 during and right after reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rsp_valid == '0, "R9 rsp_valid in reset", rsp_valid, 0);
      check(req_ready == '0, "R9 ready in reset", req_ready, 0);
      check(conflict_count == '0, "R9 count in reset", conflict_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == '0, "R9 rsp_valid after reset", rsp_valid, 0);

      // R1 R3: fill every address, four distinct banks per cycle
      for (int r = 0; r < (1 << (AW - BW)); r++) begin
         for (int p = 0; p < NP; p++)
            post(p, 1'b1, {r[AW-BW-1:OFF], p[BW-1:0], r[OFF-1:0]}, $urandom);
         cycle();
      end
      // R1 R7: read everything back
      for (int r = 0; r < (1 << (AW - BW)); r++) begin
         for (int p = 0; p < NP; p++)
            post(p, 1'b0, {r[AW-BW-1:OFF], p[BW-1:0], r[OFF-1:0]}, '0);
         cycle();
      end
      drain();

      // R4 R5 R6: all four ports on bank 0
      for (int p = 0; p < NP; p++) post(p, 1'b0, AW'(p * 16), '0);
      drain();

      // R5: port 1 held after losing must beat a re-issued port 0
      post(0, 1'b0, 8'h04, '0);
      post(1, 1'b1, 8'h15, 32'hA5A5_0001);
      cycle();
      post(0, 1'b1, 8'h25, 32'h0BAD_0002);
      cycle();
      drain();

      // R10: write then read of the same address on the next cycle
      post(2, 1'b1, 8'h3A, 32'hCAFE_F00D);
      cycle();
      post(3, 1'b0, 8'h3A, '0);
      cycle();
      drain();

      // constrained random with held requests
      for (int n = 0; n < 3000; n++) begin
         for (int p = 0; p < NP; p++) begin
            if (!pend_v[p] && ($urandom % 10) < 7)
               post(p, 1'($urandom % 2), AW'($urandom), $urandom);
         end
         cycle();
      end
      drain();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule